// File: doc/BRIEF.md
# RTC Indexed Port Interface

This block sits between an I/O decoder and a real-time-clock register file. Software reaches the clock's registers indirectly. It first writes an index to an address port and then reads or writes the selected register through the data port that belongs to the same bank. There are two independent banks, a standard one and an extended one. Each bank has its own address and data port and its own index register. Each bank's clock registers are modelled here by a 128-entry, 8-bit storage array.

A write to either address port sends a one-cycle address-latch strobe toward the clock controller. The strobe carries the index and a flag that says which bank was addressed. The standard address port also carries an NMI mask bit, which the block holds on a registered output. The address ports cannot be read on the I/O side. A shadow copy of the last byte written to the standard address port can be read back through a separate configuration read strobe. Bus timing is reduced to single-cycle read and write strobes, with at most one strobe per cycle. Read data comes back one cycle after the strobe, together with a valid pulse.

Top module: `rtc_index_port`

## Requirements
- R1: After reset `nmi_mask` is 1, both bank indices are 0, the shadow byte is 00h, and `rtc_ale`, `io_rvalid` and `cfg_rdata` are 0.
- R2: A write to port select 0 (standard address) loads the standard index from data bits 6:0 and sets `nmi_mask` to data bit 7 (1 = masked) in the following cycle. `nmi_mask` changes on no other access.
- R3: Every write to port select 0 or 2 makes `rtc_ale` high for the following cycle only. In that cycle `rtc_ale_idx` carries data bits 6:0 and `rtc_ale_ext` is 1 for select 2 and 0 for select 0. No other access raises `rtc_ale`.
- R4: Port select 1 (standard data) writes the standard-bank entry chosen by the standard index. A read of it returns that entry on `io_rdata` one cycle after the strobe.
- R5: Port select 3 (extended data) does the same for the extended bank with the extended index. The two banks hold separate storage.
- R6: Data bit 7 written to port select 2 is discarded: the extended index and `rtc_ale_idx` take only bits 6:0.
- R7: A read of port select 0 or 2 returns FFh and has no side effect: no strobe, no index or NMI mask change.
- R8: A `cfg_rd` strobe returns on `cfg_rdata`, in the following cycle, the full byte last written to port select 0.
- R9: A data-port access never changes the index of either bank.
- R10: `io_rvalid` is high in the cycle after each `io_rd` strobe, including back-to-back reads, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_port | input | 2 | Port select: 0 std address, 1 std data, 2 ext address, 3 ext data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| rtc_ale | output | 1 | Address-latch strobe to the clock controller |
| rtc_ale_ext | output | 1 | Strobe targets the extended bank |
| rtc_ale_idx | output | 7 | Index carried with the strobe |
| nmi_mask | output | 1 | NMI mask, 1 = masked |
| cfg_rd | input | 1 | Shadow read strobe |
| cfg_rdata | output | 8 | Shadow byte, updated one cycle after cfg_rd |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Read data and `io_rvalid` follow `io_rd` by one cycle. `rtc_ale`, its index and its bank flag, and `nmi_mask`, follow the address write by one cycle. `cfg_rdata` follows `cfg_rd` by one cycle. The bench drives on the falling edge. A monitor pops queued expected read bytes on the falling edge after each valid pulse. The write and shadow tasks sample the strobe, mask and shadow at the very next falling edge, so each check sees the cycle where the value first appears.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  typedef enum logic [1:0] {
    PORT_STD_ADDR = 2'd0,
    PORT_STD_DATA = 2'd1,
    PORT_EXT_ADDR = 2'd2,
    PORT_EXT_DATA = 2'd3
  } port_sel_e;

  typedef enum logic [1:0] {
    RSRC_NONE = 2'd0,
    RSRC_ADDR = 2'd1,
    RSRC_STD  = 2'd2,
    RSRC_EXT  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/rtc_port_decode.sv
module rtc_port_decode #(
  parameter int NBANK = 2
) (
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [1:0]       io_port,
  output logic [NBANK-1:0] idx_we,
  output logic [NBANK-1:0] dat_we,
  output logic [NBANK-1:0] dat_re,
  output logic             addr_rd
);
  // Port select bit 1 picks the bank, bit 0 picks data versus address.
  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    always_comb begin
      idx_we[b] = io_wr && !io_port[0] && (int'(io_port[1]) == b);
      dat_we[b] = io_wr &&  io_port[0] && (int'(io_port[1]) == b);
      dat_re[b] = io_rd &&  io_port[0] && (int'(io_port[1]) == b);
    end
  end

  assign addr_rd = io_rd && !io_port[0];
endmodule

// File: rtl/rtc_bank.sv
module rtc_bank #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_we) idx_q <= idx_in;
  end

  // Storage without reset and with a registered read port, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (dat_we) mem[idx_q] <= wdata;
    if (dat_re) rdata_q <= mem[idx_q];
  end

  assign rdata = rdata_q;

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !idx_we |=> $stable(idx_q)); // R9
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    idx_we |=> idx_q == $past(idx_in)); // R2
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
#(
  parameter int   IDX_W   = 7,
  parameter int   DATA_W  = 8,
  parameter logic NMI_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [1:0]        io_port,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic              rtc_ale,
  output logic              rtc_ale_ext,
  output logic [IDX_W-1:0]  rtc_ale_idx,
  output logic              nmi_mask,
  input  logic              cfg_rd,
  output logic [DATA_W-1:0] cfg_rdata
);
  localparam int NBANK   = 2;
  localparam int NMI_BIT = DATA_W - 1;

  logic [NBANK-1:0]  idx_we, dat_we, dat_re;
  logic              addr_rd;
  logic [DATA_W-1:0] bank_rd [NBANK];

  rtc_port_decode #(.NBANK(NBANK)) u_dec (
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_port (io_port),
    .idx_we  (idx_we),
    .dat_we  (dat_we),
    .dat_re  (dat_re),
    .addr_rd (addr_rd)
  );

  // Both banks take only the low index bits; bit 7 feeds the NMI mask or is dropped.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rtc_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .idx_we (idx_we[b]),
      .idx_in (io_wdata[IDX_W-1:0]),
      .dat_we (dat_we[b]),
      .dat_re (dat_re[b]),
      .wdata  (io_wdata),
      .rdata  (bank_rd[b])
    );
  end

  logic [DATA_W-1:0] shadow_q, cfg_q;
  logic              nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      nmi_q    <= NMI_RST;
    end else if (idx_we[0]) begin
      shadow_q <= io_wdata;
      nmi_q    <= io_wdata[NMI_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_rd) cfg_q <= shadow_q;
  end

  logic             ale_q, ale_ext_q;
  logic [IDX_W-1:0] ale_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q     <= 1'b0;
      ale_ext_q <= 1'b0;
      ale_idx_q <= '0;
    end else begin
      ale_q <= |idx_we;
      if (|idx_we) begin
        ale_ext_q <= idx_we[1];
        ale_idx_q <= io_wdata[IDX_W-1:0];
      end
    end
  end

  rd_src_e rsrc_q;
  logic    rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsrc_q   <= RSRC_NONE;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= io_rd;
      if (!io_rd)        rsrc_q <= RSRC_NONE;
      else if (addr_rd)  rsrc_q <= RSRC_ADDR;
      else if (io_port[1]) rsrc_q <= RSRC_EXT;
      else               rsrc_q <= RSRC_STD;
    end
  end

  always_comb begin
    case (rsrc_q)
      RSRC_ADDR: io_rdata = '1;
      RSRC_STD:  io_rdata = bank_rd[0];
      RSRC_EXT:  io_rdata = bank_rd[1];
      default:   io_rdata = '0;
    endcase
  end

  assign io_rvalid   = rvalid_q;
  assign rtc_ale     = ale_q;
  assign rtc_ale_ext = ale_ext_q;
  assign rtc_ale_idx = ale_idx_q;
  assign nmi_mask    = nmi_q;
  assign cfg_rdata   = cfg_q;

  AST_ALE_ON_ADDR_WR: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_port[0]) |=> rtc_ale); // R3
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && !io_port[0]) |=> !rtc_ale); // R3
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_port == PORT_STD_ADDR) |=> $stable(nmi_mask)); // R2
  AST_ADDR_RD_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_port[0]) |=> io_rdata == '1); // R7
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> io_rvalid); // R10
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> !io_rvalid); // R10
  AST_EXT_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_port == PORT_EXT_ADDR) |=>
      (rtc_ale_ext && rtc_ale_idx == $past(io_wdata[IDX_W-1:0]))); // R6
  AST_SHADOW_RD: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !idx_we[0]) |=> $stable(shadow_q) && cfg_rdata == shadow_q); // R8
endmodule

// File: tb/sim_rtc_index_port.sv
`timescale 1ns/1ps
module sim_rtc_index_port;
  logic       clk = 1'b0;
  logic       rst;
  logic       io_wr, io_rd, cfg_rd;
  logic [1:0] io_port;
  logic [7:0] io_wdata, io_rdata, cfg_rdata;
  logic       io_rvalid, rtc_ale, rtc_ale_ext, nmi_mask;
  logic [6:0] rtc_ale_idx;

  always #4 clk = ~clk;

  rtc_index_port u0 (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .rtc_ale(rtc_ale), .rtc_ale_ext(rtc_ale_ext), .rtc_ale_idx(rtc_ale_idx),
    .nmi_mask(nmi_mask), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state, derived from the requirements.
  logic [6:0] m_idx [2];
  logic [7:0] m_shadow;
  logic       m_nmi;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Tasks are called on a falling edge and return on the next one.
  task automatic wr_port(logic [1:0] p, logic [7:0] d, string tag);
    io_wr = 1'b1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    if (!p[0]) begin
      m_idx[p[1]] = d[6:0];
      if (p == 2'd0) begin m_shadow = d; m_nmi = d[7]; end
      chk({tag, " ale"}, rtc_ale, 1);
      chk({tag, " ale_idx"}, rtc_ale_idx, d[6:0]);
      chk({tag, " ale_ext"}, rtc_ale_ext, p[1]);
    end else begin
      chk({tag, " no ale"}, rtc_ale, 0);
    end
    chk({tag, " nmi"}, nmi_mask, m_nmi);
  endtask

  task automatic rd_port(logic [1:0] p, logic [7:0] exp, string tag);
    io_rd = 1'b1; io_port = p;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
    chk({tag, " no ale on read"}, rtc_ale, 0);
    chk({tag, " nmi kept"}, nmi_mask, m_nmi);
  endtask

  task automatic cfg_check(string tag);
    cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, cfg_rdata, m_shadow);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rvalid", 1, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, io_rdata, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; io_wr = 0; io_rd = 0; cfg_rd = 0; io_port = 0; io_wdata = 0;
    m_idx[0] = 0; m_idx[1] = 0; m_shadow = 8'h00; m_nmi = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 nmi_mask", nmi_mask, 1);
    chk("R1 rtc_ale", rtc_ale, 0);
    chk("R1 io_rvalid", io_rvalid, 0);
    chk("R1 cfg_rdata", cfg_rdata, 0);
    cfg_check("R1 shadow 00");
    // R1 indices start at 0
    wr_port(2'd1, 8'h3C, "R1 std data idx0");
    wr_port(2'd3, 8'h5A, "R1 ext data idx0");
    wr_port(2'd0, 8'h80, "R1 std addr 0");
    rd_port(2'd1, 8'h3C, "R1 std idx0 readback");
    wr_port(2'd2, 8'h00, "R1 ext addr 0");
    rd_port(2'd3, 8'h5A, "R1 ext idx0 readback");
    // R2 index plus NMI unmask
    wr_port(2'd0, 8'h0A, "R2 std addr unmask");
    cfg_check("R8 shadow 0A");
    // R4 standard data
    wr_port(2'd1, 8'h11, "R4 write 0A");
    rd_port(2'd1, 8'h11, "R4 read 0A");
    wr_port(2'd0, 8'h8B, "R2 std addr mask");
    wr_port(2'd1, 8'h22, "R4 write 0B");
    rd_port(2'd1, 8'h22, "R4 read 0B");
    wr_port(2'd0, 8'h0A, "R3 std addr");
    rd_port(2'd1, 8'h11, "R4 reread 0A");
    // R5 extended bank, separate storage
    wr_port(2'd2, 8'h0A, "R3 ext addr");
    wr_port(2'd3, 8'h99, "R5 ext write 0A");
    rd_port(2'd3, 8'h99, "R5 ext read 0A");
    rd_port(2'd1, 8'h11, "R5 std 0A untouched");
    // R6 bit 7 dropped on extended address
    wr_port(2'd2, 8'hF0, "R6 ext addr F0");
    wr_port(2'd3, 8'h44, "R6 ext write 70");
    wr_port(2'd2, 8'h70, "R6 ext addr 70");
    rd_port(2'd3, 8'h44, "R6 ext read 70");
    cfg_check("R6 shadow unaffected by ext");
    // R7 address port reads
    rd_port(2'd0, 8'hFF, "R7 read std addr");
    rd_port(2'd2, 8'hFF, "R7 read ext addr");
    rd_port(2'd1, 8'h11, "R7 std index kept");
    rd_port(2'd3, 8'h44, "R7 ext index kept");
    // R9 data accesses leave both indices alone
    wr_port(2'd1, 8'h66, "R9 std write");
    wr_port(2'd1, 8'h67, "R9 std write again");
    rd_port(2'd3, 8'h44, "R9 ext index after std writes");
    rd_port(2'd1, 8'h67, "R9 std index after writes");
    // Boundary index 7F, full shadow byte
    wr_port(2'd0, 8'hFF, "R2 std addr 7F masked");
    cfg_check("R8 shadow FF");
    wr_port(2'd1, 8'hA5, "R4 write 7F");
    // R10 back-to-back reads
    rd_port(2'd1, 8'hA5, "R10 b2b read 1");
    rd_port(2'd1, 8'hA5, "R10 b2b read 2");
    rd_port(2'd0, 8'hFF, "R10 b2b read 3");
    repeat (2) @(negedge clk);
    chk("R10 rvalid idle", io_rvalid, 0);
    chk("R10 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule